// File: doc/BRIEF.md
# Serial Channel Select Register

This block holds the channel number of an eight-way input selector and lets a controller change it over a three-wire serial link. The link has a shift clock, a select line and a data line. While the select line is high, each rising shift-clock edge moves one data bit into a small word register. The word is four bits long: an enable bit first, then the channel number, most significant bit first. When the select line falls, the word is checked. The new channel is accepted only if four or more bits arrived and the enable bit is one.

An accepted channel is not applied at once. It waits in a pending register and a flag is raised. The flag says that the value will apply from the next conversion. When the conversion controller pulses its start strobe, the pending value is copied to the active channel output and the flag drops. The three serial lines are asynchronous to the block clock, so they pass through a synchroniser of configurable depth. All edge detection then happens in the block clock domain.

Top module: `scs_chan_select`

## Requirements
- R1: After reset the active channel output is 0 and the pending flag is 0.
- R2: A bit is taken from the data line only on a rising edge of the shift clock while the select line is high. The first bit taken is the enable bit, followed by channel bits 2, 1 and 0 in that order.
- R3: On a falling edge of the select line, a complete word with enable bit 1 loads its three channel bits as the pending channel and sets the pending flag to 1. The active channel does not change.
- R4: A complete word whose enable bit is 0 changes neither the pending channel, nor the pending flag, nor the active channel.
- R5: Shift-clock edges that occur while the select line is low have no effect on the word being assembled or on any output.
- R6: A select-line high period in which fewer than four bits arrived changes nothing when the select line falls. This includes the case of no shift-clock edges at all.
- R7: When more than four bits arrive during one select-line high period, only the last four bits taken are used as the word.
- R8: A start strobe while the pending flag is 1 copies the pending channel to the active output on that clock edge and clears the flag. A start strobe while the flag is 0 changes nothing.
- R9: When a start strobe and an accepted commit fall on the same clock edge, the active output takes the previously pending channel (if the flag was set). The new word then becomes pending with the flag set.
- R10: A select-line fall driven between two clock edges shows on the pending flag after exactly SYNC_STAGES+1 rising clock edges. The start strobe acts on the first rising edge at which it is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mux_sclk | input | 1 | Serial shift clock, asynchronous |
| mux_sel | input | 1 | Serial select line; high while a word is shifted, its fall commits |
| mux_din | input | 1 | Serial data line |
| conv_start | input | 1 | One-cycle strobe from the conversion controller, in the clk domain |
| chan_active | output | CH_W | Channel index in use for the current conversion |
| chan_pending | output | 1 | High while a committed channel waits for the next conversion start |

## Verification
The bench builds the block with CH_W of 3 and SYNC_STAGES of 2. With these values the eight channel codes and the full three-edge latency from a select fall to the flag can both be seen in a short run. The two-stage synchroniser also puts the commit edge far enough from the serial input change that a start strobe can be placed on exactly the commit edge. That placement is what exposes the same-edge ordering case. A delay-line reference model runs in the bench and is compared with the outputs every clock. Directed checks cover short, long, disabled and ignored-clock words.

// File: rtl/scs_pkg.sv
package scs_pkg;

   localparam int unsigned SCS_MAX_SYNC = 4;
   localparam int unsigned SCS_MAX_CHW  = 8;

   typedef struct packed {
      logic lvl;
      logic rise;
      logic fall;
   } scs_edge_t;

endpackage

// File: rtl/scs_edge_sync.sv
module scs_edge_sync
   import scs_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      async_in,
   output scs_edge_t ev
);

   logic lvl_w;
   logic prev_q;

   generate
      if (SYNC_STAGES == 0) begin : g_bypass
         assign lvl_w = async_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] stg_q;
         for (genvar i = 0; i < int'(SYNC_STAGES); i++) begin : g_stage
            if (i == 0) begin : g_first
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) stg_q[0] <= 1'b0;
                  else        stg_q[0] <= async_in;
               end
            end else begin : g_next
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) stg_q[i] <= 1'b0;
                  else        stg_q[i] <= stg_q[i-1];
               end
            end
         end
         assign lvl_w = stg_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl_w;
   end

   assign ev.lvl  = lvl_w;
   assign ev.rise = lvl_w & ~prev_q;
   assign ev.fall = ~lvl_w & prev_q;

endmodule

// File: rtl/scs_word_shift.sv
module scs_word_shift #(
   parameter int unsigned WORD_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_lvl,
   input  logic              sel_fall,
   input  logic              sclk_rise,
   input  logic              din_lvl,
   output logic [WORD_W-1:0] word,
   output logic              full
);

   localparam int unsigned CNT_W = $clog2(WORD_W + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WORD_W);

   logic [WORD_W-1:0] word_q;
   logic [CNT_W-1:0]  cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
         cnt_q  <= '0;
      end else if (sel_fall) begin
         cnt_q  <= '0;
      end else if (sel_lvl && sclk_rise) begin
         word_q <= {word_q[WORD_W-2:0], din_lvl};
         if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end
   end

   assign word = word_q;
   assign full = (cnt_q == CNT_MAX);

   // R5: nothing is assembled while the select line is low
   p_low_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_lvl && !sel_fall) |=> ($stable(cnt_q) && $stable(word_q)));

   // R6: bit count never passes the word length
   p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_MAX);

   // R7: a further bit while full keeps the count at full
   p_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (full && sel_lvl && sclk_rise && !sel_fall) |=> full);

endmodule

// File: rtl/scs_chan_commit.sv
module scs_chan_commit #(
   parameter int unsigned CH_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            commit,
   input  logic            word_full,
   input  logic [CH_W:0]   word,
   input  logic            conv_start,
   output logic [CH_W-1:0] active,
   output logic            pend_flag
);

   logic [CH_W-1:0] pend_q;
   logic [CH_W-1:0] act_q;
   logic            flag_q;
   logic            accept;

   assign accept = commit & word_full & word[CH_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         act_q  <= '0;
         flag_q <= 1'b0;
      end else begin
         if (conv_start && flag_q) act_q <= pend_q;
         if (accept) begin
            pend_q <= word[CH_W-1:0];
            flag_q <= 1'b1;
         end else if (conv_start) begin
            flag_q <= 1'b0;
         end
      end
   end

   assign active    = act_q;
   assign pend_flag = flag_q;

   // R3: an accepted word raises the flag
   p_flag_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && word_full && word[CH_W]) |=> pend_flag);

   // R4: a disabled word leaves the pending channel alone
   p_disabled_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !word[CH_W]) |=> $stable(pend_q));

   // R6: a short word does not raise the flag
   p_short_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !word_full && !conv_start) |=> (pend_flag == $past(pend_flag)));

   // R8: active only moves on a start strobe
   p_active_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !conv_start |=> $stable(active));

   // R8: start without a new commit clears the flag
   p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_start && !commit) |=> !pend_flag);

endmodule

// File: rtl/scs_chan_select.sv
module scs_chan_select
   import scs_pkg::*;
#(
   parameter int unsigned CH_W        = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            mux_sclk,
   input  logic            mux_sel,
   input  logic            mux_din,
   input  logic            conv_start,
   output logic [CH_W-1:0] chan_active,
   output logic            chan_pending
);

   localparam int unsigned WORD_W = CH_W + 1;
   localparam int unsigned N_LINES = 3;
   localparam int unsigned IDX_SCLK = 0;
   localparam int unsigned IDX_SEL  = 1;
   localparam int unsigned IDX_DIN  = 2;

   generate
      if (CH_W < 1 || CH_W > SCS_MAX_CHW) begin : g_bad_chw
         $error("scs_chan_select: CH_W out of range");
      end
      if (SYNC_STAGES > SCS_MAX_SYNC) begin : g_bad_sync
         $error("scs_chan_select: SYNC_STAGES out of range");
      end
   endgenerate

   logic [N_LINES-1:0] raw_lines;
   scs_edge_t          ev [N_LINES];
   logic [WORD_W-1:0]  word;
   logic               word_full;

   assign raw_lines = {mux_din, mux_sel, mux_sclk};

   generate
      for (genvar g = 0; g < int'(N_LINES); g++) begin : g_line
         scs_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (raw_lines[g]),
            .ev       (ev[g])
         );
      end
   endgenerate

   scs_word_shift #(.WORD_W(WORD_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_lvl   (ev[IDX_SEL].lvl),
      .sel_fall  (ev[IDX_SEL].fall),
      .sclk_rise (ev[IDX_SCLK].rise),
      .din_lvl   (ev[IDX_DIN].lvl),
      .word      (word),
      .full      (word_full)
   );

   scs_chan_commit #(.CH_W(CH_W)) u_commit (
      .clk        (clk),
      .rst_n      (rst_n),
      .commit     (ev[IDX_SEL].fall),
      .word_full  (word_full),
      .word       (word),
      .conv_start (conv_start),
      .active     (chan_active),
      .pend_flag  (chan_pending)
   );

   // R9: strobe and accepted commit together leave the flag set
   p_same_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_start && ev[IDX_SEL].fall && word_full && word[CH_W]) |=> chan_pending);

endmodule

// File: tb/sim_scs_chan_select.sv
module sim_scs_chan_select;

   localparam int unsigned CH_W = 3;
   localparam int unsigned SYNC = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mux_sclk = 1'b0;
   logic mux_sel = 1'b0;
   logic mux_din = 1'b0;
   logic conv_start = 1'b0;
   logic [CH_W-1:0] chan_active;
   logic chan_pending;

   int checks = 0;
   int errors = 0;

   always #10ns clk = ~clk;

   scs_chan_select #(.CH_W(CH_W), .SYNC_STAGES(SYNC)) u0 (
      .clk(clk), .rst_n(rst_n), .mux_sclk(mux_sclk), .mux_sel(mux_sel),
      .mux_din(mux_din), .conv_start(conv_start),
      .chan_active(chan_active), .chan_pending(chan_pending)
   );

   // behavioural reference model
   int q_clk[$], q_sel[$], q_din[$];
   int m_bits[$];
   int m_pclk, m_psel, m_act, m_pend, m_flag;

   always @(posedge clk) begin
      if (!rst_n) begin
         q_clk = {}; q_sel = {}; q_din = {}; m_bits = {};
         for (int i = 0; i < SYNC; i++) begin
            q_clk.push_back(0); q_sel.push_back(0); q_din.push_back(0);
         end
         m_pclk = 0; m_psel = 0; m_act = 0; m_pend = 0; m_flag = 0;
      end else begin
         int c, s, d, acc, nw;
         q_clk.push_back(int'(mux_sclk));
         q_sel.push_back(int'(mux_sel));
         q_din.push_back(int'(mux_din));
         c = q_clk.pop_front(); s = q_sel.pop_front(); d = q_din.pop_front();
         acc = 0; nw = 0;
         if (!s && m_psel) begin
            if (m_bits.size() == 4 && m_bits[0] == 1) begin
               acc = 1; nw = m_bits[1] * 4 + m_bits[2] * 2 + m_bits[3];
            end
            m_bits = {};
         end else if (s && c && !m_pclk) begin
            m_bits.push_back(d);
            if (m_bits.size() > 4) void'(m_bits.pop_front());
         end
         if (conv_start && m_flag) m_act = m_pend;
         if (acc) begin m_pend = nw; m_flag = 1; end
         else if (conv_start) m_flag = 0;
         m_pclk = c; m_psel = s;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         checks++;
         if (int'(chan_active) != m_act || int'(chan_pending) != m_flag) begin
            errors++;
            $display("FAIL R10 model: act=%0d flag=%0d exp act=%0d flag=%0d",
                     chan_active, chan_pending, m_act, m_flag);
         end
      end
   end

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wait_n(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_clk(int b);
      mux_din = 1'(b);
      wait_n(3); mux_sclk = 1'b1;
      wait_n(3); mux_sclk = 1'b0;
      wait_n(3);
   endtask

   task automatic send_bits(int n, logic [7:0] bits);
      mux_sel = 1'b1; wait_n(3);
      for (int i = n - 1; i >= 0; i--) pulse_clk(int'(bits[i]));
   endtask

   task automatic end_word();
      mux_sel = 1'b0; wait_n(6);
   endtask

   task automatic conv();
      conv_start = 1'b1; wait_n(1); conv_start = 1'b0; wait_n(1);
   endtask

   initial begin
      #(20ns * 200000);
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      wait_n(3);
      check("R1 active", int'(chan_active), 0);
      check("R1 flag", int'(chan_pending), 0);
      rst_n = 1'b1; wait_n(2);

      // R2 R3 R10: enable 1, channel 101; latency of the flag
      send_bits(4, 8'b1101);
      mux_sel = 1'b0;
      wait_n(2);
      check("R10 flag after two edges", int'(chan_pending), 0);
      wait_n(1);
      check("R10 flag after three edges", int'(chan_pending), 1);
      check("R3 active unchanged", int'(chan_active), 0);
      wait_n(3);
      conv();
      check("R8 active after start", int'(chan_active), 5);
      check("R8 flag cleared", int'(chan_pending), 0);

      // R4: enable 0 word
      send_bits(4, 8'b0011); end_word();
      check("R4 flag", int'(chan_pending), 0);
      conv();
      check("R4 active", int'(chan_active), 5);

      // R5 R6: clocks with select low, then empty select pulse
      for (int i = 0; i < 4; i++) pulse_clk(1);
      send_bits(0, 8'b0); end_word();
      check("R5 R6 flag", int'(chan_pending), 0);
      conv();
      check("R5 active", int'(chan_active), 5);

      // R6: three bits only
      send_bits(3, 8'b111); end_word();
      check("R6 flag", int'(chan_pending), 0);

      // R7: six bits, last four are 1011
      send_bits(6, 8'b001011); end_word();
      check("R7 flag", int'(chan_pending), 1);
      conv();
      check("R7 active", int'(chan_active), 3);
      conv();
      check("R8 start without flag", int'(chan_active), 3);
      check("R8 flag stays low", int'(chan_pending), 0);

      // R9: strobe on the commit edge
      send_bits(4, 8'b1110); end_word();
      send_bits(4, 8'b1001);
      mux_sel = 1'b0;
      wait_n(2);
      conv_start = 1'b1; wait_n(1); conv_start = 1'b0;
      check("R9 active takes old pending", int'(chan_active), 6);
      check("R9 flag set by new word", int'(chan_pending), 1);
      wait_n(2);
      conv();
      check("R9 new word applied", int'(chan_active), 1);

      wait_n(4);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule